// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical address from a 16-bit offset and a 16-bit segment base. It shifts the base left by four bits and adds the offset, which gives a 1 MB space. It holds four segment base registers: code, data, stack and extra. A write port loads them. For each request, the block picks one base from the access kind and the base register that the offset was built from. An optional override input can take the place of that choice.

An execution pipeline places a request when it needs a memory address. The address and the segment that was used appear on registered outputs one clock later. The block does not decode instructions. It does not time bus cycles and it does no protection checking.

Top module: `segaddr_gen`

## Requirements
- R1: After reset, `pa_valid` and `pa_addr` read 0, and all four segment bases read 0. Segment codes on `wr_sel`, `ovr_sel` and `pa_seg`: 0 = code, 1 = data, 2 = stack, 3 = extra.
- R2: When `req_valid` is high in cycle N, `pa_valid` is high in cycle N+1 and `pa_addr` = segment*16 + `req_offset` in that cycle. `pa_valid` is low in any cycle that follows a cycle without a request.
- R3: Any carry out of bit 19 is dropped, so the address wraps modulo 2^20. For example, base FFFFh with offset 0010h gives 00000h.
- R4: `req_kind` = 0 (instruction fetch) selects the code segment when there is no override.
- R5: When there is no override, the stack segment is selected in two cases. The first is `req_kind` = 3 (stack push or pop). The second is `req_kind` = 1 (memory operand) with `req_base` = 4 (frame pointer) or 5 (stack pointer).
- R6: `req_kind` = 1 with `req_base` = 0 (direct displacement), 1 (base register), 2 (source index), 3 (destination index), 6 or 7 selects the data segment when there is no override.
- R7: `req_kind` = 2 (string destination) always selects the extra segment. An asserted override has no effect on it.
- R8: For kinds 0, 1 and 3, `ovr_valid` high replaces the default segment with `ovr_sel`.
- R9: When a segment write and a request that selects the same segment happen in the same cycle, the address is formed from the newly written value. The register keeps that value for later requests.
- R10: While `pa_valid` is low, `pa_addr` and `pa_seg` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | New segment base |
| req_valid | input | 1 | Address request |
| req_kind | input | 2 | Access kind: 0 fetch, 1 operand, 2 string destination, 3 stack op |
| req_base | input | 3 | Base register of an operand access |
| req_offset | input | 16 | Effective offset |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment |
| pa_valid | output | 1 | Address valid, one clock after the request |
| pa_addr | output | 20 | Physical address |
| pa_seg | output | 2 | Segment that was used |

## Verification
A segment write and a request can land in the same cycle. When both target the same segment, the request must see the new value. When they target different segments, it must not. The bench provokes both cases in directed steps and again in a long random phase, where write and request fields are drawn independently. Its behavioural model applies the write before it evaluates the request when the indices match. Every cycle, it compares the address and segment reported one clock later against that model.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_t;

  typedef enum logic [1:0] {
    KIND_FETCH   = 2'd0,
    KIND_OPERAND = 2'd1,
    KIND_STRDST  = 2'd2,
    KIND_STACK   = 2'd3
  } acc_kind_t;

  localparam logic [2:0] BASE_FRAME = 3'd4;
  localparam logic [2:0] BASE_STKPTR = 3'd5;
endpackage

// File: rtl/segaddr_rstsync.sv
module segaddr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/segaddr_regfile.sv
module segaddr_regfile #(
  parameter int NSEG  = 4,
  parameter int SEG_W = 16,
  localparam int IDX_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_val
);
  logic [SEG_W-1:0] seg_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic             ld;
    logic [SEG_W-1:0] nxt;

    always_comb begin
      ld  = wr_en && (wr_sel == IDX_W'(g));
      nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  seg_q[g] <= '0;
      else if (ld) seg_q[g] <= nxt;
    end
  end

  // A write in the same cycle is forwarded to the reader.
  always_comb begin
    if (wr_en && (wr_sel == rd_sel)) rd_val = wr_data;
    else                             rd_val = seg_q[rd_sel];
  end

  // R9: a write lands in the addressed register on the next edge
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/segaddr_select.sv
module segaddr_select
  import segaddr_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [2:0] base,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_sel,
  output logic [1:0] seg_sel
);
  logic [1:0] dflt;

  always_comb begin
    unique case (acc_kind_t'(kind))
      KIND_FETCH:   dflt = SEG_CODE;
      KIND_STRDST:  dflt = SEG_EXTRA;
      KIND_STACK:   dflt = SEG_STACK;
      KIND_OPERAND: dflt = ((base == BASE_FRAME) || (base == BASE_STKPTR))
                           ? SEG_STACK : SEG_DATA;
      default:      dflt = SEG_DATA;
    endcase
  end

  always_comb begin
    if (ovr_valid && (acc_kind_t'(kind) != KIND_STRDST)) seg_sel = ovr_sel;
    else                                                 seg_sel = dflt;
  end
endmodule

// File: rtl/segaddr_adder.sv
module segaddr_adder #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int IDX_W     = 2,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [IDX_W-1:0]  in_id,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [IDX_W-1:0]  out_id
);
  logic [ADDR_W-1:0] addr_nxt;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  id_q;

  // Sum is sized to ADDR_W, so the carry out of the top bit is discarded.
  always_comb begin
    addr_nxt = {in_seg, {SEG_SHIFT{1'b0}}} + ADDR_W'(in_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      id_q   <= '0;
    end else if (in_valid) begin
      addr_q <= addr_nxt;
      id_q   <= in_id;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_id    = id_q;

  // R2: one-cycle latency, no spurious valid
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10: outputs hold between requests
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_id)));
endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
  import segaddr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NSEG      = 4,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT,
  localparam int IDX_W    = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              ovr_valid,
  input  logic [IDX_W-1:0]  ovr_sel,
  output logic              pa_valid,
  output logic [ADDR_W-1:0] pa_addr,
  output logic [IDX_W-1:0]  pa_seg
);
  logic             rst_n_i;
  logic [1:0]       seg_sel;
  logic [SEG_W-1:0] seg_val;

  segaddr_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  segaddr_select u_sel (
    .kind(req_kind), .base(req_base),
    .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .seg_sel(seg_sel)
  );

  segaddr_regfile #(.NSEG(NSEG), .SEG_W(SEG_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(IDX_W'(seg_sel)), .rd_val(seg_val)
  );

  segaddr_adder #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .IDX_W(IDX_W)
  ) u_add (
    .clk(clk), .rst_n(rst_n_i),
    .in_valid(req_valid), .in_seg(seg_val), .in_off(req_offset),
    .in_id(IDX_W'(seg_sel)),
    .out_valid(pa_valid), .out_addr(pa_addr), .out_id(pa_seg)
  );

  // R4: fetch without override uses the code segment
  p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !ovr_valid && req_kind == 2'd0) |=> pa_seg == IDX_W'(0));
  // R5: stack-based accesses without override use the stack segment
  p_stack_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !ovr_valid &&
     (req_kind == 2'd3 ||
      (req_kind == 2'd1 && (req_base == 3'd4 || req_base == 3'd5))))
    |=> pa_seg == IDX_W'(2));
  // R7: string destination is pinned to the extra segment
  p_strdst_extra_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && req_kind == 2'd2) |=> pa_seg == IDX_W'(3));
  // R8: override wins for every other kind
  p_override_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && ovr_valid && req_kind != 2'd2) |=> pa_seg == $past(ovr_sel));
endmodule

// File: tb/segaddr_gen_tb_top.sv
`timescale 1ns/1ps
module segaddr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [2:0]  req_base;
  logic [15:0] req_offset;
  logic        ovr_valid;
  logic [1:0]  ovr_sel;
  logic        pa_valid;
  logic [19:0] pa_addr;
  logic [1:0]  pa_seg;

  int n_checks = 0;
  int n_fail   = 0;

  int    ref_seg [4];
  bit    exp_valid;
  int    exp_addr;
  int    exp_seg;
  int    hold_addr;
  int    hold_seg;
  string exp_tag;

  always #10 clk = ~clk;

  segaddr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_base(req_base),
    .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .pa_valid(pa_valid), .pa_addr(pa_addr), .pa_seg(pa_seg)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %05h expected %05h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (exp_valid) begin
      chk({exp_tag, " R2"}, int'(pa_valid), 1, "pa_valid");
      chk(exp_tag, int'(pa_addr), exp_addr, "pa_addr");
      chk(exp_tag, int'(pa_seg), exp_seg, "pa_seg");
      hold_addr = exp_addr;
      hold_seg  = exp_seg;
    end else begin
      chk("R2", int'(pa_valid), 0, "pa_valid idle");
      chk("R10", int'(pa_addr), hold_addr, "pa_addr hold");
      chk("R10", int'(pa_seg), hold_seg, "pa_seg hold");
    end
  endtask

  // Check last cycle's result, then drive this cycle and predict.
  task automatic step(input bit we, input int ws, input int wd,
                      input bit rv, input int kind, input int base, input int off,
                      input bit ov, input int os);
    int    s;
    int    sv;
    string tag;
    @(negedge clk);
    compare();
    wr_en = we; wr_sel = 2'(ws); wr_data = 16'(wd);
    req_valid = rv; req_kind = 2'(kind); req_base = 3'(base);
    req_offset = 16'(off); ovr_valid = ov; ovr_sel = 2'(os);
    if (kind == 2) begin s = 3; tag = "R7"; end
    else if (ov)   begin s = os; tag = "R8"; end
    else if (kind == 0) begin s = 0; tag = "R4"; end
    else if (kind == 3 || base == 4 || base == 5) begin s = 2; tag = "R5"; end
    else begin s = 1; tag = "R6"; end
    if (we && ws == s) begin sv = wd; tag = {tag, " R9"}; end
    else sv = ref_seg[s];
    if (sv * 16 + off >= 32'h100000) tag = {tag, " R3"};
    exp_valid = rv;
    if (rv) begin
      exp_addr = (sv * 16 + off) & 32'hFFFFF;
      exp_seg  = s;
      exp_tag  = tag;
    end
    if (we) ref_seg[ws] = wd;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    foreach (ref_seg[i]) ref_seg[i] = 0;
    exp_valid = 0; exp_addr = 0; exp_seg = 0; hold_addr = 0; hold_seg = 0;
    exp_tag = "";
    rst_n = 1'b0;
    wr_en = 0; wr_sel = 0; wr_data = 0; req_valid = 0; req_kind = 0;
    req_base = 0; req_offset = 0; ovr_valid = 0; ovr_sel = 0;
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk("R1", int'(pa_valid), 0, "pa_valid reset");
    chk("R1", int'(pa_addr), 0, "pa_addr reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: all segments read zero: each request returns the bare offset
    step(0,0,0, 1,0,0,16'h0010, 0,0);
    step(0,0,0, 1,1,0,16'h0020, 0,0);
    step(0,0,0, 1,3,0,16'h0030, 0,0);
    step(0,0,0, 1,2,0,16'h0040, 0,0);
    // load segments
    step(1,0,16'h2000, 0,0,0,0, 0,0);
    step(1,1,16'h1234, 0,0,0,0, 0,0);
    step(1,2,16'h3400, 0,0,0,0, 0,0);
    step(1,3,16'h4900, 0,0,0,0, 0,0);
    step(0,0,0, 1,0,0,16'h3000, 0,0);     // R4: 23000h
    step(0,0,0, 1,1,2,16'hFFFF, 0,0);     // R6: 2233Fh
    for (int b = 0; b < 8; b++) step(0,0,0, 1,1,b,16'h0100*b, 0,0); // R5/R6
    step(0,0,0, 1,3,1,16'hFFFE, 0,0);     // R5 stack op
    step(0,0,0, 1,2,3,16'h0002, 1,1);     // R7 override ignored
    step(0,0,0, 1,0,0,16'h0004, 1,2);     // R8
    step(0,0,0, 1,1,4,16'h0006, 1,3);     // R8 over stack default
    step(0,0,0, 0,0,0,0, 0,0);            // R10 idle
    step(0,0,0, 0,1,0,16'hABCD, 1,1);     // R10 idle, fields toggling
    step(1,1,16'hFFFF, 1,1,0,16'h0010, 0,0); // R9 + R3 wrap -> 00000h
    step(0,0,0, 1,1,0,16'h0011, 0,0);     // R9 value kept
    step(1,3,16'h8000, 1,1,1,16'h0005, 0,0); // write other seg, no forward
    step(1,3,16'h9000, 1,2,3,16'h0005, 1,0); // R9 on extra, R7
    for (int i = 0; i < 400; i++)
      step($urandom_range(0,1), $urandom_range(0,3), $urandom_range(0,16'hFFFF),
           $urandom_range(0,3) != 0, $urandom_range(0,3), $urandom_range(0,7),
           $urandom_range(0,16'hFFFF), $urandom_range(0,1), $urandom_range(0,3));
    step(0,0,0, 0,0,0,0, 0,0);
    step(0,0,0, 0,0,0,0, 0,0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule